// File: doc/BRIEF.md
# Serial Slot Assignment Control Interface

This block is the programming port of a frame-sync time-slot assigner. A host shifts in an 8-bit control word one bit per control-clock edge, MSB first, while holding an active-low chip select. A parallel channel-select value is sampled together with the first bit. When chip select is released after exactly eight bits, the block decodes the word. It then issues a one-cycle write strobe toward the assignment registers of the frame-sync generator. The strobe carries the target output mask, the 6-bit slot number and an enable value.

The outputs are numbered as follows: bits 0..3 of the mask are transmit outputs 0..3 and bits 4..7 are receive outputs 0..3. In pair mode the 2-bit channel select picks a transmit/receive pair, and the two leading action bits choose which side or sides of the pair are written. In single mode a 3-bit select picks any one of the eight outputs. Its top bit shares a pin with the receive-sync input. In this mode the action bits either assign the slot or switch the output off.

Top module: `slot_ctl_if`

## Requirements
- R1: The word is 8 bits, taken MSB first as action bit A1, action bit A0, then slot bits S5..S0; on a commit wr_slot_o equals S5..S0.
- R2: Data is sampled only on control-clock edges where cs_ni is low; edges with cs_ni high shift nothing and commit nothing unless a complete word is pending.
- R3: ch_i, rsync_ch2_i and mode_i are captured on the first sampled edge of a word; later changes during that word have no effect.
- R4: A commit happens on the first edge with cs_ni high after exactly 8 sampled bits. The outputs are registered, so the strobe is visible after that edge and lasts one cycle. Outside a strobe, wr_strobe_o, wr_slot_o and wr_on_o are all zero.
- R5: A word of fewer than 8 bits is discarded (no strobe).
- R6: A word of more than 8 bits is discarded (no strobe).
- R7: Pair mode (mode_i=1), channel n = ch_i: A1,A0 = 00 or 11 sets mask bits n and 4+n, 01 sets only bit n (transmit), 10 sets only bit 4+n (receive).
- R8: Single mode (mode_i=0), code c = {rsync_ch2_i, ch_i}: exactly mask bit c is set; wr_on_o is 0 when A1,A0 = 11, else 1.
- R9: In pair mode every commit is an assignment: wr_on_o = 1.
- R10: In pair mode rsync_ch2_i has no effect on the result.
- R11: Asserting rst_ni low clears the outputs and abandons a partial word; the next full word after reset is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = pair mode, 0 = single mode |
| cs_ni | input | 1 | Active-low word frame |
| data_i | input | 1 | Serial control data, MSB first |
| ch_i | input | 2 | Channel select, low bits |
| rsync_ch2_i | input | 1 | Receive-sync pin; top channel-select bit in single mode |
| wr_strobe_o | output | 8 | One-cycle write mask: [3:0] transmit, [7:4] receive |
| wr_slot_o | output | 6 | Slot number written |
| wr_on_o | output | 1 | Enable value written (1 assign, 0 disable) |

## Verification
Every word is driven on falling edges: eight bits with cs_ni low, then cs_ni high. The commit lands on the next rising edge, and the bench samples 1 ns after that edge, where the strobe and its fields are due. A second sample one cycle later confirms that the strobe has dropped. Discarded words, idle traffic and mid-word reset are checked at the same post-commit point, so a spurious strobe would be seen in the cycle it would occur.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
  localparam int NUM_CH = 4;
  localparam int SLOT_W = 6;
  localparam int WORD_W = SLOT_W + 2;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } slot_mode_e;
endpackage

// File: rtl/slot_ctl_rx.sv
module slot_ctl_rx #(
  parameter int WORD_W = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              data_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              mode_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              mode_o
);
  localparam int OVF   = WORD_W + 1;
  localparam int CNT_W = $clog2(OVF + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [CH_W-1:0]   ch_q;
  logic              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      ch_q   <= '0;
      mode_q <= 1'b1;
    end else if (!cs_ni) begin
      if (cnt_q == '0) begin
        ch_q   <= ch_i;
        mode_q <= mode_i;
      end
      if (cnt_q != CNT_W'(OVF)) cnt_q <= cnt_q + CNT_W'(1);  // saturate: too long
      sh_q <= {sh_q[WORD_W-2:0], data_i};
    end else begin
      cnt_q <= '0;
    end
  end

  assign done_o = cs_ni && (cnt_q == CNT_W'(WORD_W));
  assign word_o = sh_q;
  assign ch_o   = ch_q;
  assign mode_o = mode_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(OVF));
  p_ch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(ch_q));
  p_idle_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cnt_q == '0));
endmodule

// File: rtl/slot_ctl_dec.sv
module slot_ctl_dec
  import slot_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 6,
  localparam int WORD_W = SLOT_W + 2,
  localparam int PAIR_W = $clog2(NUM_CH),
  localparam int CH_W   = PAIR_W + 1
) (
  input  slot_mode_e        mode_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [2*NUM_CH-1:0] mask_o,
  output logic              on_o
);
  logic a1, a0, tx_sel, rx_sel;

  assign a1     = word_i[WORD_W-1];
  assign a0     = word_i[WORD_W-2];
  // pair mode: 01 transmit only, 10 receive only, 00/11 both
  assign tx_sel = !(a1 && !a0);
  assign rx_sel = !(!a1 && a0);

  always_comb begin
    mask_o = '0;
    on_o   = 1'b1;
    if (mode_i == MODE_PAIR) begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (ch_i[PAIR_W-1:0] == PAIR_W'(n)) begin
          mask_o[n]          = tx_sel;
          mask_o[NUM_CH + n] = rx_sel;
        end
      end
    end else begin
      for (int n = 0; n < 2*NUM_CH; n++) begin
        if (ch_i == CH_W'(n)) mask_o[n] = 1'b1;
      end
      on_o = !(a1 && a0);
    end
  end
endmodule

// File: rtl/slot_ctl_if.sv
module slot_ctl_if
  import slot_ctl_pkg::*;
#(
  parameter int NUM_CH_P = slot_ctl_pkg::NUM_CH,
  parameter int SLOT_W_P = slot_ctl_pkg::SLOT_W,
  localparam int PAIR_W = $clog2(NUM_CH_P),
  localparam int CH_W   = PAIR_W + 1,
  localparam int WORD_W = SLOT_W_P + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic                  cs_ni,
  input  logic                  data_i,
  input  logic [PAIR_W-1:0]     ch_i,
  input  logic                  rsync_ch2_i,
  output logic [2*NUM_CH_P-1:0] wr_strobe_o,
  output logic [SLOT_W_P-1:0]   wr_slot_o,
  output logic                  wr_on_o
);
  logic              done;
  logic [WORD_W-1:0] word;
  logic [CH_W-1:0]   ch_q;
  logic              mode_q;
  logic [2*NUM_CH_P-1:0] mask;
  logic              on;

  slot_ctl_rx #(.WORD_W(WORD_W), .CH_W(CH_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .data_i (data_i),
    .ch_i   ({rsync_ch2_i, ch_i}),
    .mode_i (mode_i),
    .done_o (done),
    .word_o (word),
    .ch_o   (ch_q),
    .mode_o (mode_q)
  );

  slot_ctl_dec #(.NUM_CH(NUM_CH_P), .SLOT_W(SLOT_W_P)) u_dec (
    .mode_i (slot_mode_e'(mode_q)),
    .ch_i   (ch_q),
    .word_i (word),
    .mask_o (mask),
    .on_o   (on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_strobe_o <= '0;
      wr_slot_o   <= '0;
      wr_on_o     <= 1'b0;
    end else if (done) begin
      wr_strobe_o <= mask;
      wr_slot_o   <= word[SLOT_W_P-1:0];
      wr_on_o     <= on;
    end else begin
      wr_strobe_o <= '0;
      wr_slot_o   <= '0;
      wr_on_o     <= 1'b0;
    end
  end

  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strobe_o) |=> (wr_strobe_o == '0));
  p_commit_cs_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strobe_o) |-> $past(cs_ni));
  p_single_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|wr_strobe_o) && mode_q == MODE_SINGLE) |-> ($countones(wr_strobe_o) == 1));
  p_pair_assign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|wr_strobe_o) && mode_q == MODE_PAIR) |-> wr_on_o);
  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o == '0) |-> (!wr_on_o && wr_slot_o == '0));
endmodule

// File: tb/slot_ctl_if_tb.sv
module slot_ctl_if_tb_top;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic       mode;
    logic [2:0] ch;
    logic [7:0] word;
    logic [7:0] mask;
    logic       on;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 8'h05, 8'h11, 1'b1},  // R7 00 both
    '{1'b1, 3'd1, 8'h7F, 8'h02, 1'b1},  // R7 01 tx only, slot 63
    '{1'b1, 3'd2, 8'h80, 8'h40, 1'b1},  // R7 10 rx only, slot 0
    '{1'b1, 3'd3, 8'hEA, 8'h88, 1'b1},  // R7 11 both
    '{1'b0, 3'd0, 8'h01, 8'h01, 1'b1},  // R8
    '{1'b0, 3'd5, 8'h61, 8'h20, 1'b1},  // R8
    '{1'b0, 3'd3, 8'h91, 8'h08, 1'b1},  // R8
    '{1'b0, 3'd7, 8'hC9, 8'h80, 1'b0},  // R8 disable
    '{1'b1, 3'd5, 8'h4C, 8'h02, 1'b1},  // R10 ch2 ignored
    '{1'b0, 3'd4, 8'h3E, 8'h10, 1'b1}   // R8 receive 0
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b1;
  logic cs_ni = 1'b1;
  logic data_i = 1'b0;
  logic [1:0] ch_i = '0;
  logic rsync_ch2_i = 1'b0;
  logic [7:0] wr_strobe_o;
  logic [5:0] wr_slot_o;
  logic wr_on_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  slot_ctl_if dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cs_ni(cs_ni),
    .data_i(data_i), .ch_i(ch_i), .rsync_ch2_i(rsync_ch2_i),
    .wr_strobe_o(wr_strobe_o), .wr_slot_o(wr_slot_o), .wr_on_o(wr_on_o)
  );

  task automatic check(input string req, input logic [7:0] m, input logic [5:0] s, input logic o);
    n_chk++;
    if (wr_strobe_o !== m || wr_slot_o !== s || wr_on_o !== o) begin
      n_fail++;
      $display("FAIL %s: got mask=%h slot=%0d on=%b, exp mask=%h slot=%0d on=%b",
               req, wr_strobe_o, wr_slot_o, wr_on_o, m, s, o);
    end
  endtask

  // drives nb bits, then releases cs; returns 1 ns after the commit edge
  task automatic send(input logic m, input logic [2:0] c, input logic [7:0] w,
                      input int nb, input bit chg);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk_i);
      if (i == 0) begin
        mode_i = m; ch_i = c[1:0]; rsync_ch2_i = c[2];
      end
      if (chg && i == 1) begin
        mode_i = ~m; ch_i = ~c[1:0]; rsync_ch2_i = ~c[2];
      end
      cs_ni  = 1'b0;
      data_i = (i < 8) ? w[7-i] : 1'b1;
    end
    @(negedge clk_i);
    cs_ni = 1'b1;
    data_i = 1'b0;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 reset", 8'h00, 6'd0, 1'b0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R11 after release", 8'h00, 6'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v].mode, VEC[v].ch, VEC[v].word, 8, 1'b0);
      check("R1 R7 R8 R9 R10 vector", VEC[v].mask, VEC[v].word[5:0], VEC[v].on);
      @(posedge clk_i); #1;
      check("R4 strobe one cycle", 8'h00, 6'd0, 1'b0);
    end

    // R2: idle traffic with cs high
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); data_i = i[0];
      @(posedge clk_i); #1;
      check("R2 idle no strobe", 8'h00, 6'd0, 1'b0);
    end

    // R3: select and mode changed mid-word
    send(1'b0, 3'd6, 8'h15, 8, 1'b1);
    check("R3 select latched", 8'h40, 6'd21, 1'b1);

    // R5 short word, then a clean word
    send(1'b1, 3'd2, 8'h0A, 7, 1'b0);
    check("R5 short discarded", 8'h00, 6'd0, 1'b0);
    send(1'b1, 3'd2, 8'h0A, 8, 1'b0);
    check("R5 recovery", 8'h44, 6'd10, 1'b1);

    // R6 long word
    send(1'b0, 3'd1, 8'h2B, 9, 1'b0);
    check("R6 long discarded", 8'h00, 6'd0, 1'b0);
    send(1'b0, 3'd1, 8'h2B, 8, 1'b0);
    check("R6 recovery", 8'h02, 6'd43, 1'b1);

    // R11 reset mid-word
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); cs_ni = 1'b0; data_i = 1'b1;
    end
    @(negedge clk_i); rst_ni = 1'b0; cs_ni = 1'b1;
    #1;
    check("R11 mid-word reset", 8'h00, 6'd0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R11 no stale commit", 8'h00, 6'd0, 1'b0);
    send(1'b1, 3'd3, 8'h63, 8, 1'b0);
    check("R11 word after reset", 8'h08, 6'd35, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule